// File: doc/BRIEF.md
# Execute-Stage Operand Bypass Unit

This block sits in front of the ALU of a five-stage, 32-bit, single-issue RISC pipeline. For the instruction now in the execute stage it compares the two source register numbers with the destination register numbers carried by the next two pipeline registers. The first of these is the execute/memory register, which holds the instruction one slot ahead. The second is the memory/writeback register, which holds the instruction two slots ahead. From that comparison it derives a 2-bit select code per operand. It then steers one of three values onto each ALU operand: the register-file value, the ALU result from the execute/memory register, or the writeback value from the memory/writeback register.

The select logic and the operand multiplexers are purely combinational. Nothing is registered and there is no stream traffic at this boundary, so every pin is a plain control or data signal with no valid/ready handshake. The register file writes in the first half of a cycle and is read in the second half. A producer three or more slots ahead is therefore already visible through the register-file value and needs no bypass. The load-use stall, the ALU and the register file live outside this block.

Top module: `exe_bypass`

## Requirements
- R1: Each operand select is a 2-bit code with three meanings: 2'b00 takes the register-file value, 2'b01 takes the memory/writeback result, and 2'b10 takes the execute/memory result. Code 2'b11 is never produced.
- R2: An operand selects 2'b10 when the execute/memory instruction writes a register (write enable high), that destination is nonzero, and it equals the operand's source register number.
- R3: An operand selects 2'b01 when the memory/writeback instruction writes a nonzero destination equal to the operand's source register, and the R2 condition is false for that same operand.
- R4: When both later stages write the register an operand reads, the newer execute/memory result wins (select 2'b10).
- R5: A destination of register 0 is never forwarded. A source of register 0 always gives select 2'b00, which passes through the register-file value (zero).
- R6: An instruction whose write enable is low causes no forwarding, even when its destination field matches.
- R7: With no qualifying match the select is 2'b00 and the register-file value passes through. This covers a producer three or more slots ahead and an empty pipeline.
- R8: Each operand output equals the value its select code names, in the same cycle.
- R9: Operand A (rs) and operand B (rt) are decided independently. Both may forward at once, from the same or from different stages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_src_a | input | 5 | rs number of the instruction in execute |
| ex_src_b | input | 5 | rt number of the instruction in execute |
| ex_rf_a | input | 32 | register-file value read for rs |
| ex_rf_b | input | 32 | register-file value read for rt |
| em_wr_en | input | 1 | execute/memory instruction writes a register |
| em_dst | input | 5 | execute/memory destination register number |
| em_result | input | 32 | ALU result held in execute/memory |
| mw_wr_en | input | 1 | memory/writeback instruction writes a register |
| mw_dst | input | 5 | memory/writeback destination register number |
| mw_result | input | 32 | writeback value held in memory/writeback |
| sel_a | output | 2 | select code for operand A |
| sel_b | output | 2 | select code for operand B |
| opnd_a | output | 32 | ALU operand A |
| opnd_b | output | 32 | ALU operand B |

## Verification
The bench plays an instruction stream through a behavioural pipeline model. The model keeps a queue of in-flight instructions and an architectural register file. Consumers are placed one, two and three slots behind their producers, so the execute/memory path, the writeback path and the plain register path are each told apart. Further directed patterns separate the other cases: two back-to-back writers of one register (priority), a writer of register 0, a matching but non-writing instruction, and both operands forwarding from different stages. A long random stream over a few registers then mixes all of these, so that hit combinations arise which the directed cases do not list.

// File: rtl/bypass_pkg.sv
package bypass_pkg;
  localparam int unsigned SEL_W = 2;

  // operand source select; codes are decoded by the operand multiplexer
  typedef enum logic [SEL_W-1:0] {
    SRC_RF   = 2'b00,
    SRC_LATE = 2'b01,
    SRC_NEAR = 2'b10
  } opnd_src_e;
endpackage

// File: rtl/bypass_hit.sv
module bypass_hit #(
  parameter int unsigned AW = 5
) (
  input  logic [AW-1:0] src,
  input  logic          wr_en,
  input  logic [AW-1:0] dst,
  output logic          hit
);
  always_comb begin
    hit = wr_en && (dst != '0) && (dst == src);
  end
endmodule

// File: rtl/bypass_pick.sv
module bypass_pick
  import bypass_pkg::*;
#(
  parameter int unsigned AW = 5
) (
  input  logic [AW-1:0] src,
  input  logic          em_wr_en,
  input  logic [AW-1:0] em_dst,
  input  logic          mw_wr_en,
  input  logic [AW-1:0] mw_dst,
  output opnd_src_e     sel
);
  logic near_hit;
  logic late_hit;

  bypass_hit #(.AW(AW)) i_near (
    .src(src), .wr_en(em_wr_en), .dst(em_dst), .hit(near_hit)
  );
  bypass_hit #(.AW(AW)) i_late (
    .src(src), .wr_en(mw_wr_en), .dst(mw_dst), .hit(late_hit)
  );

  always_comb begin
    if (near_hit)      sel = SRC_NEAR;
    else if (late_hit) sel = SRC_LATE;
    else               sel = SRC_RF;
  end

  always_comb begin
    if (!$isunknown({src, em_wr_en, em_dst, mw_wr_en, mw_dst, sel})) begin
      // R5
      src_zero_chk: assert (src != '0 || sel == SRC_RF)
        else $error("register zero forwarded");
      // R6
      no_writer_chk: assert (em_wr_en || mw_wr_en || sel == SRC_RF)
        else $error("forward without any writer");
      // R4
      near_prio_chk: assert (!(em_wr_en && em_dst == src && src != '0) || sel == SRC_NEAR)
        else $error("newer result not preferred");
      // R1
      code_legal_chk: assert (sel != opnd_src_e'(2'b11))
        else $error("illegal select code");
    end
  end
endmodule

// File: rtl/bypass_mux.sv
module bypass_mux
  import bypass_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  opnd_src_e     sel,
  input  logic [DW-1:0] rf_val,
  input  logic [DW-1:0] near_val,
  input  logic [DW-1:0] late_val,
  output logic [DW-1:0] opnd
);
  always_comb begin
    case (sel)
      SRC_NEAR: opnd = near_val;
      SRC_LATE: opnd = late_val;
      default:  opnd = rf_val;
    endcase
  end
endmodule

// File: rtl/exe_bypass.sv
module exe_bypass
  import bypass_pkg::*;
#(
  parameter int unsigned AW = 5,
  parameter int unsigned DW = 32
) (
  input  logic [AW-1:0]    ex_src_a,
  input  logic [AW-1:0]    ex_src_b,
  input  logic [DW-1:0]    ex_rf_a,
  input  logic [DW-1:0]    ex_rf_b,
  input  logic             em_wr_en,
  input  logic [AW-1:0]    em_dst,
  input  logic [DW-1:0]    em_result,
  input  logic             mw_wr_en,
  input  logic [AW-1:0]    mw_dst,
  input  logic [DW-1:0]    mw_result,
  output logic [SEL_W-1:0] sel_a,
  output logic [SEL_W-1:0] sel_b,
  output logic [DW-1:0]    opnd_a,
  output logic [DW-1:0]    opnd_b
);
  localparam int unsigned NUM_OPND = 2;

  logic [AW-1:0] src_v  [NUM_OPND];
  logic [DW-1:0] rf_v   [NUM_OPND];
  opnd_src_e     sel_v  [NUM_OPND];
  logic [DW-1:0] opnd_v [NUM_OPND];

  assign src_v[0] = ex_src_a;
  assign src_v[1] = ex_src_b;
  assign rf_v[0]  = ex_rf_a;
  assign rf_v[1]  = ex_rf_b;

  for (genvar g = 0; g < NUM_OPND; g++) begin : g_opnd
    bypass_pick #(.AW(AW)) i_pick (
      .src(src_v[g]),
      .em_wr_en(em_wr_en), .em_dst(em_dst),
      .mw_wr_en(mw_wr_en), .mw_dst(mw_dst),
      .sel(sel_v[g])
    );
    bypass_mux #(.DW(DW)) i_mux (
      .sel(sel_v[g]), .rf_val(rf_v[g]),
      .near_val(em_result), .late_val(mw_result),
      .opnd(opnd_v[g])
    );
  end

  assign sel_a  = sel_v[0];
  assign sel_b  = sel_v[1];
  assign opnd_a = opnd_v[0];
  assign opnd_b = opnd_v[1];

  always_comb begin
    if (!$isunknown({sel_a, sel_b, opnd_a, opnd_b, em_result, mw_result, ex_rf_a, ex_rf_b})) begin
      // R8
      opnd_a_route_chk: assert ((sel_a == 2'b10 && opnd_a == em_result) ||
                                (sel_a == 2'b01 && opnd_a == mw_result) ||
                                (sel_a == 2'b00 && opnd_a == ex_rf_a))
        else $error("operand A not routed per select");
      // R8
      opnd_b_route_chk: assert ((sel_b == 2'b10 && opnd_b == em_result) ||
                                (sel_b == 2'b01 && opnd_b == mw_result) ||
                                (sel_b == 2'b00 && opnd_b == ex_rf_b))
        else $error("operand B not routed per select");
    end
  end
endmodule

// File: tb/test_exe_bypass.sv
module test_exe_bypass;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [4:0]  ex_src_a, ex_src_b, em_dst, mw_dst;
  logic [31:0] ex_rf_a, ex_rf_b, em_result, mw_result;
  logic        em_wr_en, mw_wr_en;
  logic [1:0]  sel_a, sel_b;
  logic [31:0] opnd_a, opnd_b;

  exe_bypass i_exe_bypass (
    .ex_src_a(ex_src_a), .ex_src_b(ex_src_b),
    .ex_rf_a(ex_rf_a), .ex_rf_b(ex_rf_b),
    .em_wr_en(em_wr_en), .em_dst(em_dst), .em_result(em_result),
    .mw_wr_en(mw_wr_en), .mw_dst(mw_dst), .mw_result(mw_result),
    .sel_a(sel_a), .sel_b(sel_b), .opnd_a(opnd_a), .opnd_b(opnd_b)
  );

  typedef struct {
    logic [4:0]  dst;
    logic        we;
    logic [31:0] val;
  } instr_t;

  instr_t      flight_q[$];
  logic [31:0] arch_rf [32];
  int          n_checks = 0;
  int          n_errors = 0;
  int          serial   = 0;

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // behavioural view: nearest older in-flight writer of src, else the register file
  function automatic int older_writer(logic [4:0] src);
    for (int k = 0; k < flight_q.size() && k < 2; k++)
      if (src != 0 && flight_q[k].we && flight_q[k].dst == src) return k;
    return -1;
  endfunction

  function automatic string tag_for(int k);
    if (k == 0) return "R2";
    if (k == 1) return "R3";
    return "R7";
  endfunction

  task automatic issue(string tag, logic [4:0] sa, logic [4:0] sb, logic [4:0] dst, logic we);
    int ka, kb;
    logic [1:0] es_a, es_b;
    logic [31:0] ev_a, ev_b;
    string ta, tb;
    @(posedge clk); #1;
    ex_src_a = sa; ex_src_b = sb;
    ex_rf_a = arch_rf[sa]; ex_rf_b = arch_rf[sb];
    if (flight_q.size() > 0) begin
      em_wr_en = flight_q[0].we; em_dst = flight_q[0].dst; em_result = flight_q[0].val;
    end else begin
      em_wr_en = 1'b0; em_dst = '0; em_result = 32'hDEAD_0001;
    end
    if (flight_q.size() > 1) begin
      mw_wr_en = flight_q[1].we; mw_dst = flight_q[1].dst; mw_result = flight_q[1].val;
    end else begin
      mw_wr_en = 1'b0; mw_dst = '0; mw_result = 32'hDEAD_0002;
    end
    ka = older_writer(sa);
    kb = older_writer(sb);
    es_a = (ka == 0) ? 2'b10 : (ka == 1) ? 2'b01 : 2'b00;
    es_b = (kb == 0) ? 2'b10 : (kb == 1) ? 2'b01 : 2'b00;
    ev_a = (ka >= 0) ? flight_q[ka].val : arch_rf[sa];
    ev_b = (kb >= 0) ? flight_q[kb].val : arch_rf[sb];
    ta = (tag == "") ? tag_for(ka) : tag;
    tb = (tag == "") ? tag_for(kb) : tag;
    @(negedge clk);
    check({ta, " R1"}, "sel_a", {30'd0, sel_a}, {30'd0, es_a});
    check({tb, " R1"}, "sel_b", {30'd0, sel_b}, {30'd0, es_b});
    check("R8", "opnd_a", opnd_a, ev_a);
    check("R8", "opnd_b", opnd_b, ev_b);
    serial++;
    flight_q.push_front('{dst: dst, we: we, val: 32'hC0DE_0000 + serial});
    if (flight_q.size() > 2) begin
      instr_t old;
      old = flight_q.pop_back();
      if (old.we && old.dst != 0) arch_rf[old.dst] = old.val;
    end
  endtask

  initial begin
    #(5 * 150000);
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) arch_rf[i] = (i == 0) ? 32'd0 : 32'h1000_0000 + i;
    em_wr_en = 1'b0; mw_wr_en = 1'b0; em_dst = '0; mw_dst = '0;
    ex_src_a = '0; ex_src_b = '0; ex_rf_a = '0; ex_rf_b = '0;
    em_result = '0; mw_result = '0;

    issue("R7", 5'd1, 5'd2, 5'd5, 1'b1);   // empty pipeline, reset-like state
    issue("R2", 5'd5, 5'd3, 5'd6, 1'b1);   // distance 1 on A
    issue("R3", 5'd4, 5'd5, 5'd7, 1'b1);   // distance 2 on B
    issue("R7", 5'd5, 5'd5, 5'd8, 1'b1);   // distance 3: register file
    issue("R4", 5'd1, 5'd2, 5'd9, 1'b1);
    issue("R4", 5'd1, 5'd2, 5'd9, 1'b1);
    issue("R4", 5'd9, 5'd9, 5'd11, 1'b1);  // both stages write 9: newer wins
    issue("R5", 5'd1, 5'd2, 5'd0, 1'b1);
    issue("R5", 5'd0, 5'd0, 5'd12, 1'b1);  // writer of reg 0 ahead
    issue("R5", 5'd0, 5'd0, 5'd12, 1'b1);  // reg 0 writer two ahead
    issue("R6", 5'd1, 5'd2, 5'd13, 1'b0);
    issue("R6", 5'd13, 5'd13, 5'd14, 1'b0); // non-writer one ahead
    issue("R6", 5'd13, 5'd14, 5'd15, 1'b1); // non-writers at both stages
    issue("R9", 5'd1, 5'd1, 5'd16, 1'b1);
    issue("R9", 5'd2, 5'd3, 5'd17, 1'b1);
    issue("R9", 5'd17, 5'd16, 5'd18, 1'b1); // A near, B late
    for (int n = 0; n < 400; n++)
      issue("", 5'($urandom_range(0, 3)), 5'($urandom_range(0, 3)),
            5'($urandom_range(0, 3)), 1'($urandom_range(0, 1)));

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule